// File: doc/BRIEF.md
# Flow-through burst SRAM with no turnaround cycles

This block is a synthesizable behavioural model of a synchronous SRAM. Every control and address input is registered on the rising clock, and read data flows from the array to the data outputs in the same cycle as the registered address, with no output register. The data of a write is taken one enabled clock after its address. Because of this, a read and a write can follow each other on consecutive clocks with no idle cycle between them.

An access either loads a new address and operation or continues the current burst. A two-bit counter steps through up to four locations around the loaded address, in a wrapping sequential order or in an XOR order. A clock enable freezes the whole pipeline. Per-byte write strobes can drop single lanes or abort a whole write beat. The block resolves a read of a location whose write data has not yet reached the array. Three chip-select inputs gate new accesses, and a sleep input parks the outputs. The data bus is split into an input vector, an output vector and an output-enable flag, so that high impedance is represented as `dq_en` low. The array depth is a parameter.

Top module: `fts_sram`

## Requirements
- R1: A rising edge with `rst_n` low clears the block. After it `dq_en` is 0, no burst is running and no write is pending.
- R2: An edge with `cke_n` high (and `sleep` low) changes nothing. No address, control, data or strobe is captured, no write reaches the array, the burst position is held, and `dq_en`/`dq_o` keep their values.
- R3: An enabled edge with `burst_adv` = 0, the chip selected and `wr_n` = 1 starts a read of `addr`. In the following cycle, while `oe_n` = 0, `dq_en` is 1 and `dq_o` shows the content of that location (flow-through).
- R4: An enabled edge with `burst_adv` = 1 during a running burst moves to the next beat k (k = 1, 2, 3, then wrapping to 0). The upper address bits stay at the loaded value. The low two bits are start+k mod 4 when the order latched at load was `ord_xor` = 0, and start XOR k when it was 1. The operation and the order are latched at load, and changes to `wr_n` or `ord_xor` during the burst have no effect.
- R5: The chip is selected only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. A load edge with any other combination deselects the block. `dq_en` is 0 in the next cycle, and later advance edges leave it deselected.
- R6: A write started by a load edge with `wr_n` = 0 takes `dq_i` and `be_n` at the next enabled edge. Lane i is `dq_i[9i+8:9i]`, with bit 9i+8 as its parity bit. Only lanes with `be_n[i]` = 0 are written, and the other lanes keep their contents.
- R7: A write beat whose strobes are all 1 is aborted, and the addressed location is left unchanged.
- R8: `dq_en` is 0 whenever `oe_n` = 1, and during the data cycle of every write beat whatever the value of `oe_n`.
- R9: A read of a location whose write data was taken at the same edge returns the new lanes merged with the old ones, with no idle cycle between them.
- R10: While `sleep` = 1, `dq_en` is 0 and edges capture nothing. After `sleep` returns to 0, `dq_en` stays 0 and advance edges stay idle until a new selected read load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 1 continues the burst, 0 loads a new address |
| wr_n | input | 1 | 0 starts a write, 1 a read, at a load edge |
| be_n | input | NBYTES | Per-lane write strobes, active low, data cycle |
| oe_n | input | 1 | Output enable, active low |
| ord_xor | input | 1 | Burst order: 0 wrapping sequential, 1 XOR |
| sleep | input | 1 | Sleep request, only while deselected |
| addr | input | AW | Word address |
| dq_i | input | 9*NBYTES | Write data with one parity bit per lane |
| dq_o | output | 9*NBYTES | Read data |
| dq_en | output | 1 | High when `dq_o` drives the bus; low is high impedance |

## Verification
The bench builds the block with two byte lanes and a five-bit address, so the array holds 32 words. At that size it can write and read back every word, and it can run bursts from all four start offsets in both orders, for both reads and writes. The same size keeps every select combination and every strobe pattern within a short run. A bench-side architectural memory gives the expected read values at each beat. Stalls, aborted beats and write-then-read of the same word can therefore be placed at any point of a burst.

// File: rtl/fts_pkg.sv
// Shared types and helpers of the flow-through burst SRAM.
// Assumes: burst offsets are two bits wide.
package fts_pkg;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } burst_order_e;

    // Low address bits of beat k of a burst that started at offset start.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] k,
                                            input burst_order_e ord);
        logic [1:0] r;
        if (ord == ORD_XOR) r = start ^ k;
        else                r = start + k;
        return r;
    endfunction

endpackage

// File: rtl/fts_burst_ctrl.sv
// Access sequencer: decodes load/advance, keeps the burst counter and the
// latched operation and order, and registers the address of the current beat.
// Assumes: AW >= 3; step is the clock-enable qualified edge, nap overrides it.
module fts_burst_ctrl #(
    parameter int AW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    nap,
    input  logic                    chip_on,
    input  logic                    adv,
    input  logic                    wr_req,
    input  logic [AW-1:0]           addr,
    input  fts_pkg::burst_order_e   ord_in,
    output logic                    acc_valid,
    output logic                    acc_wr,
    output logic [AW-1:0]           acc_addr
);
    import fts_pkg::*;

    logic         run;
    logic         run_wr;
    logic [AW-1:0] base;
    logic [1:0]   k;
    logic [1:0]   k_nxt;
    burst_order_e ord;

    // Next burst offset.
    assign k_nxt = k + 2'd1;

    // Sequence loads, advances, deselects and sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            run_wr    <= 1'b0;
            base      <= '0;
            k         <= '0;
            ord       <= ORD_WRAP;
            acc_valid <= 1'b0;
            acc_wr    <= 1'b0;
            acc_addr  <= '0;
        end else if (nap) begin
            run       <= 1'b0;
            acc_valid <= 1'b0;
        end else if (step) begin
            if (!adv) begin
                if (chip_on) begin
                    run       <= 1'b1;
                    run_wr    <= wr_req;
                    base      <= addr;
                    k         <= 2'd0;
                    ord       <= ord_in;
                    acc_valid <= 1'b1;
                    acc_wr    <= wr_req;
                    acc_addr  <= addr;
                end else begin
                    run       <= 1'b0;
                    acc_valid <= 1'b0;
                end
            end else if (run) begin
                k         <= k_nxt;
                acc_valid <= 1'b1;
                acc_wr    <= run_wr;
                acc_addr  <= {base[AW-1:2], beat_low(base[1:0], k_nxt, ord)};
            end else begin
                acc_valid <= 1'b0;
            end
        end
    end

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !nap) |=> ($stable(acc_addr) && $stable(acc_valid) && $stable(acc_wr)));

    assert_wrap_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !nap && adv && run && ord == ORD_WRAP) |=>
        (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1 && $stable(acc_addr[AW-1:2])));

    assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !nap && !adv && !chip_on) |=> !acc_valid);

endmodule

// File: rtl/fts_wbuf.sv
// Write buffer: takes write data and strobes one enabled edge after the write
// address and holds them until the next enabled edge commits them to the array.
// Assumes: LW-bit lanes; a beat with every strobe high leaves nothing pending.
module fts_wbuf #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int LW = 9,
    localparam int DW = NB * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          acc_valid,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] din,
    input  logic [NB-1:0] be_n,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data,
    output logic [NB-1:0] wb_lane,
    output logic          commit
);

    // Capture the data cycle of the beat registered at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
            wb_lane  <= '0;
        end else if (step) begin
            wb_valid <= acc_valid && acc_wr && !(&be_n);
            wb_addr  <= acc_addr;
            wb_data  <= din;
            wb_lane  <= ~be_n;
        end
    end

    // The pending beat reaches the array at the next enabled edge.
    assign commit = step && wb_valid;

    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && acc_valid && acc_wr && (&be_n)) |=> !wb_valid);

    assert_buf_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(wb_valid) && $stable(wb_data) && $stable(wb_addr)));

endmodule

// File: rtl/fts_array.sv
// Storage array: one memory per byte lane, written per lane, read
// combinationally for flow-through output.
// Assumes: contents are not reset; depth is 2**AW words.
module fts_array #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int LW = 9,
    localparam int DW = NB * LW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wlane,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];

        // Write this lane when its strobe is part of the committed beat.
        always_ff @(posedge clk) begin
            if (we && wlane[g]) lane_mem[waddr] <= wdata[g*LW +: LW];
        end

        // Flow-through read of this lane.
        assign rdata[g*LW +: LW] = lane_mem[raddr];
    end

endmodule

// File: rtl/fts_sram.sv
// Flow-through burst SRAM with delayed write data. Decodes the chip selects,
// clock enable and sleep, and merges pending write lanes into read data.
// Assumes: sleep is raised only while deselected; dq_en low means high impedance.
module fts_sram #(
    parameter int NBYTES = 2,
    parameter int AW     = 6,
    localparam int LW    = 9,
    localparam int DW    = NBYTES * LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              burst_adv,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] be_n,
    input  logic              oe_n,
    input  logic              ord_xor,
    input  logic              sleep,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     dq_i,
    output logic [DW-1:0]     dq_o,
    output logic              dq_en
);

    logic              step;
    logic              chip_on;
    logic              acc_valid;
    logic              acc_wr;
    logic [AW-1:0]     acc_addr;
    logic              wb_valid;
    logic [AW-1:0]     wb_addr;
    logic [DW-1:0]     wb_data;
    logic [NBYTES-1:0] wb_lane;
    logic              commit;
    logic [DW-1:0]     arr_q;
    logic              hit;

    // Qualified edge and chip-select decode.
    assign step    = !cke_n && !sleep;
    assign chip_on = !sel_a_n && sel_b && !sel_c_n;

    fts_burst_ctrl #(.AW(AW)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .nap       (sleep),
        .chip_on   (chip_on),
        .adv       (burst_adv),
        .wr_req    (!wr_n),
        .addr      (addr),
        .ord_in    (fts_pkg::burst_order_e'(ord_xor)),
        .acc_valid (acc_valid),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr)
    );

    fts_wbuf #(.AW(AW), .NB(NBYTES), .LW(LW)) i_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .acc_valid (acc_valid),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .din       (dq_i),
        .be_n      (be_n),
        .wb_valid  (wb_valid),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .wb_lane   (wb_lane),
        .commit    (commit)
    );

    fts_array #(.AW(AW), .NB(NBYTES), .LW(LW)) i_array (
        .clk   (clk),
        .we    (commit),
        .waddr (wb_addr),
        .wdata (wb_data),
        .wlane (wb_lane),
        .raddr (acc_addr),
        .rdata (arr_q)
    );

    // Pending write targets the word being read.
    assign hit = wb_valid && (wb_addr == acc_addr);

    // Merge pending lanes into the array word, lane by lane.
    for (genvar g = 0; g < NBYTES; g++) begin : g_fwd
        assign dq_o[g*LW +: LW] = (hit && wb_lane[g]) ? wb_data[g*LW +: LW]
                                                      : arr_q[g*LW +: LW];
    end

    // Drive the bus only for a read beat with output enable and no sleep.
    assign dq_en = acc_valid && !acc_wr && !oe_n && !sleep;

    assert_write_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !burst_adv && chip_on && !wr_n) |=> !dq_en);

    assert_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !burst_adv && chip_on && wr_n) |=> (dq_en || oe_n || sleep));

    assert_wake_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> !dq_en);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> !dq_en);

endmodule

// File: tb/test_fts_sram.sv
`timescale 1ns/1ps
module test_fts_sram;
    localparam int NB    = 2;
    localparam int AW    = 5;
    localparam int LW    = 9;
    localparam int DW    = NB * LW;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] SEL_ON = 3'b010;

    logic          clk = 1'b0;
    logic          rst_n, cke_n, sel_a_n, sel_b, sel_c_n, burst_adv, wr_n, oe_n, ord_xor, sleep;
    logic [NB-1:0] be_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_i, dq_o;
    logic          dq_en;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    // Bench-side architectural model.
    logic [DW-1:0] ref_mem [DEPTH];
    logic          m_run, m_runwr, m_valid, m_wr, m_ord, exp_en;
    logic [AW-1:0] m_base, m_cur;
    logic [1:0]    m_k;

    always #10 clk = ~clk;

    fts_sram #(.NBYTES(NB), .AW(AW)) i_fts_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .burst_adv(burst_adv), .wr_n(wr_n), .be_n(be_n), .oe_n(oe_n),
        .ord_xor(ord_xor), .sleep(sleep), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
    );

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'((a * 1237 + s * 4099 + 5) ^ (a << 9) ^ (s << 13));
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model, sample at the next falling edge.
    task automatic cyc(input logic c, input logic adv, input logic w, input logic [2:0] s,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be,
                       input string tag);
        cke_n = c; burst_adv = adv; wr_n = w; {sel_a_n, sel_b, sel_c_n} = s;
        addr = a; dq_i = d; be_n = be;
        if (sleep) begin
            m_valid = 1'b0; m_run = 1'b0;
        end else if (!c) begin
            if (m_valid && m_wr)
                for (int g = 0; g < NB; g++)
                    if (!be[g]) ref_mem[m_cur][g*LW +: LW] = d[g*LW +: LW];
            if (!adv) begin
                if (s == SEL_ON) begin
                    m_run = 1'b1; m_runwr = !w; m_base = a; m_k = 2'd0; m_ord = ord_xor;
                    m_valid = 1'b1; m_wr = !w; m_cur = a;
                end else begin
                    m_run = 1'b0; m_valid = 1'b0;
                end
            end else if (m_run) begin
                m_k = m_k + 2'd1;
                m_cur = {m_base[AW-1:2], m_ord ? (m_base[1:0] ^ m_k) : 2'(m_base[1:0] + m_k)};
                m_valid = 1'b1; m_wr = m_runwr;
            end else begin
                m_valid = 1'b0;
            end
        end
        @(negedge clk);
        exp_en = m_valid && !m_wr && !oe_n && !sleep;
        check(tag, "dq_en", 32'(dq_en), 32'(exp_en));
        if (exp_en) check(tag, "dq_o", 32'(dq_o), 32'(ref_mem[m_cur]));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cke_n = 1'b1; {sel_a_n, sel_b, sel_c_n} = 3'b101; burst_adv = 1'b0;
        wr_n = 1'b1; be_n = '1; oe_n = 1'b0; ord_xor = 1'b0; sleep = 1'b0; addr = '0; dq_i = '0;
        m_run = 1'b0; m_runwr = 1'b0; m_valid = 1'b0; m_wr = 1'b0; m_ord = 1'b0;
        m_base = '0; m_cur = '0; m_k = '0;
        repeat (3) @(negedge clk);
        check("R1", "dq_en", 32'(dq_en), 32'd0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, SEL_ON, '0, '0, '1, "R1");
        cyc(1'b0, 1'b1, 1'b1, SEL_ON, '0, '0, '1, "R1");

        // R6: back-to-back single writes of every word.
        for (int a = 0; a < DEPTH; a++)
            cyc(1'b0, 1'b0, 1'b0, SEL_ON, AW'(a), pat(a + DEPTH - 1, 0), 2'b00, "R6");
        cyc(1'b0, 1'b0, 1'b1, 3'b000, '0, pat(DEPTH - 1, 0), 2'b00, "R6");

        // R3: read every word back.
        for (int a = 0; a < DEPTH; a++)
            cyc(1'b0, 1'b0, 1'b1, SEL_ON, AW'(a), '0, 2'b11, "R3");

        // R9, R6, R7: write then immediately read the same word, every strobe pattern.
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1'b0, 1'b0, 1'b0, SEL_ON, AW'(a), '0, 2'b11, "R8");
            cyc(1'b0, 1'b0, 1'b1, SEL_ON, AW'(a), pat(a, 1), 2'(a % 4), (a % 4 == 3) ? "R7" : "R9");
            cyc(1'b0, 1'b0, 1'b1, SEL_ON, AW'(a ^ 3), '0, 2'b11, "R9");
        end

        // R4, R2, R7: write and read bursts from every start offset in both orders.
        for (int o = 0; o < 2; o++) begin
            for (int st = 0; st < 4; st++) begin
                logic [AW-1:0] b;
                b = {3'(o * 2 + 1), 2'(st)};
                ord_xor = 1'(o);
                cyc(1'b0, 1'b0, 1'b0, SEL_ON, b, '0, 2'b11, "R4");
                ord_xor = 1'(1 - o);
                for (int bt = 1; bt <= 4; bt++) begin
                    cyc(1'b0, 1'b1, 1'b1, SEL_ON, '0, pat(b, bt),
                        (bt == 2) ? 2'b11 : ((bt == 3) ? 2'b10 : 2'b00), (bt == 3) ? "R7" : "R4");
                    if (bt == 1) begin
                        cyc(1'b1, 1'b1, 1'b0, SEL_ON, '0, '1, 2'b00, "R2");
                        cyc(1'b1, 1'b0, 1'b0, SEL_ON, '1, '1, 2'b00, "R2");
                    end
                end
                cyc(1'b0, 1'b0, 1'b1, 3'b100, '0, pat(b, 9), 2'b01, "R6");
                ord_xor = 1'(o);
                cyc(1'b0, 1'b0, 1'b1, SEL_ON, b, '0, 2'b11, "R4");
                ord_xor = 1'(1 - o);
                for (int bt = 1; bt <= 5; bt++) begin
                    cyc(1'b0, 1'b1, 1'b0, SEL_ON, '0, '0, 2'b00, "R4");
                    if (bt == 2) cyc(1'b1, 1'b0, 1'b0, 3'b000, '1, '1, 2'b00, "R2");
                end
            end
        end
        ord_xor = 1'b0;

        // R8: output enable high during a read.
        oe_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, SEL_ON, 5'd3, '0, 2'b11, "R8");
        oe_n = 1'b0;
        cyc(1'b1, 1'b0, 1'b1, SEL_ON, 5'd3, '0, 2'b11, "R8");

        // R5: every chip-select combination, then an advance.
        for (int s = 0; s < 8; s++) begin
            cyc(1'b0, 1'b0, 1'b1, 3'(s), AW'(s + 4), '0, 2'b11, "R5");
            cyc(1'b0, 1'b1, 1'b1, SEL_ON, '0, '0, 2'b11, "R5");
        end

        // R10: sleep masks output, captures nothing, and output stays parked on exit.
        cyc(1'b0, 1'b0, 1'b1, SEL_ON, 5'd9, '0, 2'b11, "R10");
        sleep = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 3'b101, '0, '0, 2'b11, "R10");
        cyc(1'b0, 1'b0, 1'b0, SEL_ON, 5'd9, '1, 2'b00, "R10");
        cyc(1'b0, 1'b0, 1'b1, SEL_ON, 5'd9, '1, 2'b00, "R10");
        sleep = 1'b0;
        cyc(1'b1, 1'b0, 1'b1, 3'b101, '0, '0, 2'b11, "R10");
        cyc(1'b0, 1'b1, 1'b1, SEL_ON, '0, '0, 2'b11, "R10");
        cyc(1'b0, 1'b0, 1'b1, SEL_ON, 5'd9, '0, 2'b11, "R10");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule